// File: doc/BRIEF.md
# Per-Thread Reorder Buffer Quota Tracker

This block keeps the entry accounting for a reorder buffer shared by several hardware threads. It counts how many entries each thread holds and derives a per-thread ceiling from a selectable sharing mode, the total capacity, a threshold value and the mask of running threads. From these it reports how many entries remain in the whole buffer and within each thread's quota. It also raises a per-thread stall flag that the rename or dispatch stage uses to hold that thread back.

Each cycle a thread may ask for one new entry, return one entry at commit, and return a batch of entries after a flush. Allocation requests are checked against the current quotas, so an over-eager front end cannot push the buffer past its limits. Ceilings are held in registers and follow changes to the mode, capacity, threshold or thread mask one clock later.

Top module: `rob_quota_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, every thread holds zero entries, so global_free equals cfg_total.
- R2: With cfg_policy 0 or 3 (shared mode), every thread's ceiling is cfg_total.
- R3: With cfg_policy 1 (split mode), a thread whose active_mask bit is set gets cfg_total divided by the number of set mask bits, rounded down. A thread whose bit is clear gets cfg_total divided by the thread count, and so does every thread when the mask is zero.
- R4: With cfg_policy 2 (capped mode), each thread's ceiling is cfg_thresh. When exactly one mask bit is set, that thread's ceiling is cfg_total instead.
- R5: A ceiling is registered. A change of cfg_policy, cfg_thresh, cfg_total or active_mask reaches thread_free only after the next rising clock edge.
- R6: thread_free of a thread is its ceiling minus its occupancy, and it is zero when the occupancy is at or above the ceiling.
- R7: global_free is cfg_total minus the sum of all occupancies, and it is zero when the sum is at or above cfg_total.
- R8: An accepted allocation adds one to the thread's occupancy. A retire takes one away, and the thread's squash_rel field takes away its value. Occupancy never goes below zero, and an allocation and a retire in the same cycle leave it unchanged.
- R9: An allocation request is ignored when its thread's thread_free is zero or global_free is zero.
- R10: If more threads request entries than global_free allows, requests are granted in ascending thread index until the free entries are used up.
- R11: stall of a thread is high exactly when its thread_free is zero or global_free is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_policy | input | 2 | Sharing mode: 0 shared, 1 split, 2 capped, 3 shared |
| cfg_total | input | CW | Total buffer capacity |
| cfg_thresh | input | CW | Per-thread ceiling in capped mode |
| active_mask | input | NT | One bit per running thread |
| alloc | input | NT | Per-thread request for one entry |
| retire | input | NT | Per-thread commit of one entry |
| squash_rel | input | NT*SW | Per-thread count of entries freed by a flush, thread t in bits [t*SW +: SW] |
| global_free | output | CW | Free entries in the whole buffer |
| thread_free | output | NT*CW | Free entries in each thread's quota, thread t in bits [t*CW +: CW] |
| stall | output | NT | Per-thread hold-off flag |

## Verification
The cycle-by-cycle properties cover the aggregate count. It is fixed after reset. It never grows while nothing is retired or flushed. It falls by at most the number of requests in a cycle. It stays at zero when full with nothing leaving, and a zero count stalls every thread. The ceiling formulas for each mode and mask, their one-cycle delay, the saturation of a thread's count above a lowered ceiling, and the grant order among competing threads depend on the configuration. Only the bench's mode and mask sweep and its traffic runs against an arithmetic model show these.

// File: rtl/rqt_pkg.sv
package rqt_pkg;

    typedef enum logic [1:0] {
        SHARE_ALL   = 2'd0,
        SHARE_SPLIT = 2'd1,
        SHARE_CAP   = 2'd2,
        SHARE_RSVD  = 2'd3
    } share_mode_e;

    // The reserved encoding behaves as the shared mode.
    function automatic share_mode_e decode_mode(input logic [1:0] raw);
        share_mode_e m;
        case (raw)
            2'd1:    m = SHARE_SPLIT;
            2'd2:    m = SHARE_CAP;
            default: m = SHARE_ALL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/rqt_ceiling.sv
module rqt_ceiling
    import rqt_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  share_mode_e            mode,
    input  logic [CW-1:0]          total,
    input  logic [CW-1:0]          thresh,
    input  logic [NT-1:0]          mask,
    output logic [NT-1:0][CW-1:0]  ceil_q
);
    localparam int AW = $clog2(NT + 1);

    logic [AW-1:0]         n_act;
    logic [CW-1:0]         even_share;
    logic [CW-1:0]         act_share;
    logic                  one_act;
    logic [NT-1:0][CW-1:0] ceil_d;

    always_comb begin
        n_act      = AW'($countones(mask));
        even_share = total / CW'(NT);
        act_share  = (n_act == '0) ? even_share : total / CW'(n_act);
        one_act    = (n_act == AW'(1));
    end

    for (genvar t = 0; t < NT; t++) begin : g_ceil
        always_comb begin
            case (mode)
                SHARE_SPLIT: ceil_d[t] = mask[t] ? act_share : even_share;
                SHARE_CAP:   ceil_d[t] = (one_act && mask[t]) ? total : thresh;
                default:     ceil_d[t] = total;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ceil_q <= '0;
        else     ceil_q <= ceil_d;
    end

endmodule

// File: rtl/rqt_grant.sv
module rqt_grant #(
    parameter int NT = 4,
    parameter int CW = 6
) (
    input  logic [NT-1:0] req,
    input  logic [NT-1:0] quota_empty,
    input  logic [CW-1:0] pool_free,
    output logic [NT-1:0] grant
);
    logic [CW-1:0] taken;

    // Lower index first; each grant consumes one shared free entry.
    always_comb begin
        taken = '0;
        grant = '0;
        for (int t = 0; t < NT; t++) begin
            if (req[t] && !quota_empty[t] && (taken < pool_free)) begin
                grant[t] = 1'b1;
                taken    = taken + CW'(1);
            end
        end
    end

endmodule

// File: rtl/rqt_slot.sv
module rqt_slot #(
    parameter int CW = 6,
    parameter int SW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          drop_one,
    input  logic [SW-1:0] drop_many,
    input  logic [CW-1:0] ceil,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] room
);
    logic [CW:0] up;
    logic [CW:0] down;

    always_comb begin
        up   = {1'b0, occ} + {{CW{1'b0}}, take};
        down = {{CW{1'b0}}, drop_one} + {{(CW + 1 - SW){1'b0}}, drop_many};
        room = (ceil > occ) ? ceil - occ : '0;
    end

    always_ff @(posedge clk) begin
        if (rst)            occ <= '0;
        else if (up > down) occ <= CW'(up - down);
        else                occ <= '0;
    end

endmodule

// File: rtl/rob_quota_tracker.sv
module rob_quota_tracker
    import rqt_pkg::*;
#(
    parameter int NT = 4,
    parameter int CW = 6,
    parameter int SW = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_policy,
    input  logic [CW-1:0]    cfg_total,
    input  logic [CW-1:0]    cfg_thresh,
    input  logic [NT-1:0]    active_mask,
    input  logic [NT-1:0]    alloc,
    input  logic [NT-1:0]    retire,
    input  logic [NT*SW-1:0] squash_rel,
    output logic [CW-1:0]    global_free,
    output logic [NT*CW-1:0] thread_free,
    output logic [NT-1:0]    stall
);
    localparam int SUMW = CW + $clog2(NT) + 1;

    share_mode_e           mode;
    logic [NT-1:0][CW-1:0] ceil_q;
    logic [NT-1:0][CW-1:0] occ;
    logic [NT-1:0][CW-1:0] room;
    logic [NT-1:0]         room_zero;
    logic [NT-1:0]         grant;
    logic [SUMW-1:0]       occ_sum;

    assign mode = decode_mode(cfg_policy);

    rqt_ceiling #(.NT(NT), .CW(CW)) u_ceiling (
        .clk    (clk),
        .rst    (rst),
        .mode   (mode),
        .total  (cfg_total),
        .thresh (cfg_thresh),
        .mask   (active_mask),
        .ceil_q (ceil_q)
    );

    rqt_grant #(.NT(NT), .CW(CW)) u_grant (
        .req         (alloc),
        .quota_empty (room_zero),
        .pool_free   (global_free),
        .grant       (grant)
    );

    for (genvar t = 0; t < NT; t++) begin : g_slot
        rqt_slot #(.CW(CW), .SW(SW)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .take      (grant[t]),
            .drop_one  (retire[t]),
            .drop_many (squash_rel[t*SW +: SW]),
            .ceil      (ceil_q[t]),
            .occ       (occ[t]),
            .room      (room[t])
        );
        assign room_zero[t]             = (room[t] == '0);
        assign thread_free[t*CW +: CW]  = room[t];
        assign stall[t]                 = room_zero[t] || (global_free == '0);
    end

    always_comb begin
        occ_sum = '0;
        for (int t = 0; t < NT; t++) begin
            occ_sum = occ_sum + SUMW'(occ[t]);
        end
        global_free = (SUMW'(cfg_total) > occ_sum) ? CW'(SUMW'(cfg_total) - occ_sum) : '0;
    end

endmodule

// File: rtl/rqt_checker.sv
module rqt_checker #(
    parameter int NT = 4,
    parameter int CW = 6,
    parameter int SW = 3
) (
    input logic             clk,
    input logic             rst,
    input logic [CW-1:0]    cfg_total,
    input logic [NT-1:0]    alloc,
    input logic [NT-1:0]    retire,
    input logic [NT*SW-1:0] squash_rel,
    input logic [CW-1:0]    global_free
    ,
    input logic [NT-1:0]    stall
);
    // R1
    after_reset_free_chk: assert property (@(posedge clk)
        rst |=> (global_free == cfg_total));

    // R9
    full_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (global_free == '0 && retire == '0 && squash_rel == '0)
        |=> ($stable(cfg_total) -> global_free == '0));

    // R7
    free_monotone_chk: assert property (@(posedge clk) disable iff (rst)
        (retire == '0 && squash_rel == '0)
        |=> ($stable(cfg_total) -> global_free <= $past(global_free)));

    // R8
    alloc_bound_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($stable(cfg_total) ->
            (int'(global_free) + $countones($past(alloc)) >= int'($past(global_free)))));

    // R11
    full_stalls_chk: assert property (@(posedge clk) disable iff (rst)
        (global_free == '0) |-> (&stall));

endmodule

bind rob_quota_tracker rqt_checker #(.NT(NT), .CW(CW), .SW(SW)) u_rqt_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_total   (cfg_total),
    .alloc       (alloc),
    .retire      (retire),
    .squash_rel  (squash_rel),
    .global_free (global_free),
    .stall       (stall)
);

// File: tb/tb_rob_quota_tracker.sv
`timescale 1ns/1ps
module tb_rob_quota_tracker;
    localparam int NT = 4;
    localparam int CW = 6;
    localparam int SW = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cfg_policy = 2'd0;
    logic [CW-1:0]    cfg_total = 6'd13;
    logic [CW-1:0]    cfg_thresh = 6'd5;
    logic [NT-1:0]    active_mask = 4'hF;
    logic [NT-1:0]    alloc = '0;
    logic [NT-1:0]    retire = '0;
    logic [NT*SW-1:0] squash_rel = '0;
    logic [CW-1:0]    global_free;
    logic [NT*CW-1:0] thread_free;
    logic [NT-1:0]    stall;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int mocc[NT];
    int mceil[NT];
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    rob_quota_tracker #(.NT(NT), .CW(CW), .SW(SW)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int ceil_of(int t);
        int n = $countones(active_mask);
        int tot = int'(cfg_total);
        case (cfg_policy)
            2'd1: return (n == 0 || !active_mask[t]) ? tot / NT : tot / n;
            2'd2: return (n == 1 && active_mask[t]) ? tot : int'(cfg_thresh);
            default: return tot;
        endcase
    endfunction

    function automatic int gfree_m();
        int s = 0;
        for (int t = 0; t < NT; t++) s += mocc[t];
        return (int'(cfg_total) > s) ? int'(cfg_total) - s : 0;
    endfunction

    function automatic int tfree_m(int t);
        return (mceil[t] > mocc[t]) ? mceil[t] - mocc[t] : 0;
    endfunction

    task automatic check_all();
        int g = gfree_m();
        chk("R7", int'(global_free), g);
        for (int t = 0; t < NT; t++) begin
            int f = tfree_m(t);
            chk("R6", int'(thread_free[t*CW +: CW]), f);
            chk("R11", int'(stall[t]), (f == 0 || g == 0) ? 1 : 0);
        end
    endtask

    task automatic step(input logic [NT-1:0] a, input logic [NT-1:0] r, input logic [NT*SW-1:0] s);
        int g;
        int taken = 0;
        int nxt[NT];
        @(negedge clk);
        alloc = a; retire = r; squash_rel = s;
        g = gfree_m();
        for (int t = 0; t < NT; t++) begin
            int acc = 0;
            if (a[t] && tfree_m(t) > 0 && taken < g) begin
                acc = 1;
                taken++;
            end
            nxt[t] = mocc[t] + acc - int'(r[t]) - int'(s[t*SW +: SW]);
            if (nxt[t] < 0) nxt[t] = 0;
        end
        @(posedge clk);
        #1;
        for (int t = 0; t < NT; t++) begin
            mocc[t]  = nxt[t];
            mceil[t] = ceil_of(t);
        end
        alloc = '0; retire = '0; squash_rel = '0;
        check_all();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int t = 0; t < NT; t++) begin mocc[t] = 0; mceil[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0;
        chk("R1", int'(global_free), 13);
        step('0, '0, '0);
        chk("R1", int'(global_free), 13);

        // R2 R3 R4 R5: sweep every mode and mask with an empty buffer
        for (int p = 0; p < 4; p++) begin
            for (int m = 0; m < 16; m++) begin
                string tag;
                cfg_policy  = 2'(p);
                active_mask = 4'(m);
                #0;
                chk("R5", int'(thread_free[CW-1:0]), mceil[0]);
                step('0, '0, '0);
                tag = (p == 1) ? "R3" : (p == 2) ? "R4" : "R2";
                for (int t = 0; t < NT; t++)
                    chk(tag, int'(thread_free[t*CW +: CW]), ceil_of(t));
            end
        end

        // R8: allocate, allocate with retire, then an oversized flush
        cfg_policy = 2'd0; active_mask = 4'hF;
        step('0, '0, '0);
        step(4'b0001, '0, '0);
        chk("R8", int'(thread_free[CW-1:0]), 12);
        step(4'b0001, 4'b0001, '0);
        chk("R8", int'(thread_free[CW-1:0]), 12);
        step('0, '0, 12'd3);
        chk("R8", int'(thread_free[CW-1:0]), 13);

        // R9: capped mode, thread 1 exhausts its quota of 5
        cfg_policy = 2'd2;
        step('0, '0, '0);
        for (int i = 0; i < 6; i++) step(4'b0010, '0, '0);
        chk("R9", int'(thread_free[CW +: CW]), 0);
        chk("R9", int'(global_free), 8);

        // R10: shared mode, leave two free entries, three threads compete
        cfg_policy = 2'd0;
        step('0, '0, 12'(5 << SW));
        for (int i = 0; i < 11; i++) step(4'b0001, '0, '0);
        chk("R10", int'(global_free), 2);
        step(4'b1110, '0, '0);
        chk("R10", int'(thread_free[CW +: CW]), 12);
        chk("R10", int'(thread_free[3*CW +: CW]), 13);
        chk("R10", int'(global_free), 0);

        // R6: lowered ceiling below occupancy saturates at zero
        cfg_policy = 2'd1;
        step('0, '0, '0);
        chk("R6", int'(thread_free[CW-1:0]), 0);
        step('0, '0, 12'o7777);
        step('0, '0, 12'o7777);

        // Mixed traffic across modes and masks
        for (int i = 0; i < 3000; i++) begin
            logic [NT*SW-1:0] sq;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (i % 300 == 0) begin
                cfg_policy  = 2'(i / 300);
                active_mask = lf[3:0];
                cfg_thresh  = 6'(3 + lf[6:4]);
            end
            sq = (lf[15:13] == 3'd0) ? {lf[2:0], lf[5:3], lf[8:6], lf[11:9]} & 12'o3333 : '0;
            step(lf[7:4], lf[11:8] & lf[3:0], sq);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule